// File: doc/BRIEF.md
# Tracking Channel Phase Measurement Unit

This block is the timing core of one satellite tracking channel. It holds three phase accumulators (code, carrier and sub-carrier), each advanced by its own programmable 32-bit increment on every cycle in which the sample enable is high. A carry out of an accumulator marks one whole cycle for the carrier and sub-carrier, or one half chip for the code. A programmable interval timer counts enabled samples and produces a measurement strobe (the TIC). On that strobe, all measurements are captured together in one clock edge.

The captured values are the upper 16 bits of each accumulator's phase, the code position in half chips, and the number of carrier and sub-carrier cycles that completed since the previous strobe. A processor reads them over a plain 16-bit register bus. A second, shorter timer sets a ready flag that drives the interrupt line, and reading the flag clears it. The code replica can be slipped back by a programmed number of half chips. Correlators and accumulation arithmetic live elsewhere.

Top module: `trk_meas_unit`

## Requirements
- R1: Each accumulator adds its committed 32-bit increment, modulo 2^32, exactly once per clock in which `samp_en` is high. The fraction readbacks return bits 31..16 of the phase as it stands after the addition made in the TIC sample.
- R2: The increments use these write address pairs: carrier 0/1, code 2/3, sub-carrier 4/5. The TIC period uses the pair 6/7. In each pair the even address stages the upper 16 bits and the odd address commits {staged, written}. A write to the even address alone leaves the value in use unchanged.
- R3: Let P be the committed TIC period. `tic_o` is high, combinationally, in the enabled sample that completes P enabled samples. The count runs from the previous TIC or from the clock after the last write to address 7, whichever is later.
- R4: On a TIC, the read addresses take these values: 16 returns the code fraction, 18 the carrier fraction and 21 the sub-carrier fraction. These values hold until the next TIC. Unmapped and write-only addresses read as 0.
- R5: The code position counts code carries modulo HALF_CHIPS (default 2046). It is captured on the TIC, including any carry made in that sample, and is read at address 16+1 = 17.
- R6: Carrier and sub-carrier carries are counted over each TIC interval, including the TIC sample itself. The count is captured and cleared to zero in the same clock, so no carry is lost or counted twice. The carrier count reads at 19 (low half) and 20 (high half); the sub-carrier count reads at 22 (low half) and 23 (high half).
- R7: Writing N to address 9 makes the next N code carries leave the code position unchanged. Each swallowed carry consumes one count. A new write replaces the remaining count.
- R8: Address 8 holds the accumulation period Q. In the enabled sample that completes Q enabled samples, the ready flag is set from the next clock. `irq_o` equals the flag.
- R9: A read (`rd_en` high) of address 24 returns the flag in bit 0 and clears it at that clock edge. If the accumulation timer fires in the same clock, the flag stays set.
- R10: While `samp_en` is low, no phase, count, timer or snapshot advances, and neither the TIC nor the accumulation event occurs.
- R11: A TIC period of 0 or an accumulation period of 0 disables that timer.
- R12: After synchronous reset, every readback and both outputs are 0, and all increments and periods are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Sample enable; one accumulator step per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the ready flag on address 24) |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| tic_o | output | 1 | Measurement strobe, one clock wide |
| irq_o | output | 1 | Accumulation-ready interrupt (flag level) |

## Verification
The checker assumes that at most one register is addressed per clock. It also assumes that the periods change only through their commit writes, so a running timer never sees its limit drop below its count. The bench drives one write or read per clock on the falling edge and varies the sample enable in gaps, both while the timers run and while increments and slew are rewritten. It therefore never meets a condition outside these assumptions. The bench compares the strobe, interrupt and read data on every clock against a behavioural model, including the code wrap at HALF_CHIPS and the set-over-clear race on the flag.

// File: rtl/trk_pkg.sv
package trk_pkg;
    localparam int BUS_W  = 16;
    localparam int PH_W   = 2 * BUS_W;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_CARR_INC_HI = 5'd0,
        A_CARR_INC_LO = 5'd1,
        A_CODE_INC_HI = 5'd2,
        A_CODE_INC_LO = 5'd3,
        A_SUB_INC_HI  = 5'd4,
        A_SUB_INC_LO  = 5'd5,
        A_TIC_HI      = 5'd6,
        A_TIC_LO      = 5'd7,
        A_ACC_PER     = 5'd8,
        A_SLEW        = 5'd9,
        A_CODE_FRAC   = 5'd16,
        A_CODE_HC     = 5'd17,
        A_CARR_FRAC   = 5'd18,
        A_CARR_CYC_LO = 5'd19,
        A_CARR_CYC_HI = 5'd20,
        A_SUB_FRAC    = 5'd21,
        A_SUB_CYC_LO  = 5'd22,
        A_SUB_CYC_HI  = 5'd23,
        A_STATUS      = 5'd24
    } reg_addr_e;

    // snapshot of one cycle-counting oscillator
    typedef struct packed {
        logic [BUS_W-1:0] frac;
        logic [PH_W-1:0]  cycles;
    } meas_t;

    function automatic logic [BUS_W-1:0] upper_half(input logic [PH_W-1:0] v);
        return v[PH_W-1:BUS_W];
    endfunction

    function automatic logic [BUS_W-1:0] lower_half(input logic [PH_W-1:0] v);
        return v[BUS_W-1:0];
    endfunction
endpackage

// File: rtl/trk_wide_reg.sv
module trk_wide_reg
    import trk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [BUS_W-1:0] wdata,
    output logic [PH_W-1:0]  value_o
);
    logic [BUS_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            value_o <= '0;
        end else begin
            if (wr_hi)
                stage_q <= wdata;
            if (wr_lo)
                value_o <= {stage_q, wdata};
        end
    end
endmodule

// File: rtl/trk_dco.sv
module trk_dco
    import trk_pkg::*;
#(
    parameter int W      = PH_W,
    parameter int FRAC_W = BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [W-1:0]      inc,
    output logic [FRAC_W-1:0] frac_next_o,
    output logic              carry_o
);
    logic [W-1:0] phase_q;
    logic [W:0]   sum;

    always_comb begin
        sum         = {1'b0, phase_q} + {1'b0, inc};
        frac_next_o = sum[W-1 -: FRAC_W];
        carry_o     = en & sum[W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (en)
            phase_q <= sum[W-1:0];
    end
endmodule

// File: rtl/trk_interval_timer.sv
module trk_interval_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         restart,
    input  logic [W-1:0] period,
    output logic         strobe_o
);
    logic [W-1:0] cnt_q;
    logic         off;

    assign off      = (period == '0);
    assign strobe_o = en && !off && (cnt_q == period - W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (en)
            cnt_q <= (strobe_o || off) ? '0 : cnt_q + W'(1);
    end
endmodule

// File: rtl/trk_cycle_meas.sv
module trk_cycle_meas
    import trk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             carry,
    input  logic             tic,
    input  logic [BUS_W-1:0] frac_next,
    output meas_t            snap_o
);
    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] cnt_next;

    assign cnt_next = cnt_q + PH_W'(carry);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            snap_o <= '0;
        end else if (tic) begin
            snap_o.frac   <= frac_next;
            snap_o.cycles <= cnt_next;
            cnt_q         <= '0;
        end else begin
            cnt_q <= cnt_next;
        end
    end
endmodule

// File: rtl/trk_code_track.sv
module trk_code_track
    import trk_pkg::*;
#(
    parameter int HALF_CHIPS = 2046,
    localparam int HC_W      = $clog2(HALF_CHIPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             carry,
    input  logic             tic,
    input  logic [BUS_W-1:0] frac_next,
    input  logic             slew_wr,
    input  logic [BUS_W-1:0] slew_val,
    output logic [BUS_W-1:0] snap_frac_o,
    output logic [HC_W-1:0]  snap_hc_o
);
    logic [HC_W-1:0]  hc_q;
    logic [HC_W-1:0]  hc_next;
    logic [BUS_W-1:0] slew_q;
    logic             swallow;

    always_comb begin
        swallow = carry && (slew_q != '0);
        hc_next = hc_q;
        if (carry && !swallow)
            hc_next = (hc_q == HC_W'(HALF_CHIPS - 1)) ? '0 : hc_q + HC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hc_q        <= '0;
            slew_q      <= '0;
            snap_frac_o <= '0;
            snap_hc_o   <= '0;
        end else begin
            hc_q <= hc_next;
            if (slew_wr)
                slew_q <= slew_val;
            else if (swallow)
                slew_q <= slew_q - BUS_W'(1);
            if (tic) begin
                snap_frac_o <= frac_next;
                snap_hc_o   <= hc_next;
            end
        end
    end
endmodule

// File: rtl/trk_meas_unit.sv
module trk_meas_unit
    import trk_pkg::*;
#(
    parameter int HALF_CHIPS = 2046,
    parameter int ACC_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              tic_o,
    output logic              irq_o
);
    localparam int HC_W   = $clog2(HALF_CHIPS);
    localparam int N_WIDE = 4;   // carrier, code, sub-carrier, TIC period
    localparam int N_DCO  = 3;   // carrier, code, sub-carrier
    localparam int N_MEAS = 2;   // carrier, sub-carrier
    localparam int I_CODE = 1;
    localparam int I_TIC  = 3;

    logic [PH_W-1:0]  wide_val  [N_WIDE];
    logic [BUS_W-1:0] dco_frac  [N_DCO];
    logic [N_DCO-1:0] dco_carry;
    meas_t            meas_q    [N_MEAS];
    logic [ACC_W-1:0] acc_per_q;
    logic             acc_stb;
    logic             ready_q;
    logic [BUS_W-1:0] code_snap_frac;
    logic [HC_W-1:0]  code_snap_hc;

    // staged 32-bit programming registers
    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        trk_wide_reg u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_hi   (wr_en && addr == ADDR_W'(2 * g)),
            .wr_lo   (wr_en && addr == ADDR_W'(2 * g + 1)),
            .wdata   (wdata),
            .value_o (wide_val[g])
        );
    end

    // phase accumulators
    for (genvar g = 0; g < N_DCO; g++) begin : g_dco
        trk_dco #(.W(PH_W), .FRAC_W(BUS_W)) u_dco (
            .clk         (clk),
            .rst         (rst),
            .en          (samp_en),
            .inc         (wide_val[g]),
            .frac_next_o (dco_frac[g]),
            .carry_o     (dco_carry[g])
        );
    end

    trk_interval_timer #(.W(PH_W)) u_tic (
        .clk      (clk),
        .rst      (rst),
        .en       (samp_en),
        .restart  (wr_en && addr == A_TIC_LO),
        .period   (wide_val[I_TIC]),
        .strobe_o (tic_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            acc_per_q <= '0;
        else if (wr_en && addr == A_ACC_PER)
            acc_per_q <= ACC_W'(wdata);
    end

    trk_interval_timer #(.W(ACC_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .en       (samp_en),
        .restart  (wr_en && addr == A_ACC_PER),
        .period   (acc_per_q),
        .strobe_o (acc_stb)
    );

    // cycle counters for the carrier (dco 0) and sub-carrier (dco 2)
    for (genvar m = 0; m < N_MEAS; m++) begin : g_meas
        localparam int SRC = (m == 0) ? 0 : 2;
        trk_cycle_meas u_meas (
            .clk       (clk),
            .rst       (rst),
            .carry     (dco_carry[SRC]),
            .tic       (tic_o),
            .frac_next (dco_frac[SRC]),
            .snap_o    (meas_q[m])
        );
    end

    trk_code_track #(.HALF_CHIPS(HALF_CHIPS)) u_code (
        .clk         (clk),
        .rst         (rst),
        .carry       (dco_carry[I_CODE]),
        .tic         (tic_o),
        .frac_next   (dco_frac[I_CODE]),
        .slew_wr     (wr_en && addr == A_SLEW),
        .slew_val    (wdata),
        .snap_frac_o (code_snap_frac),
        .snap_hc_o   (code_snap_hc)
    );

    // ready flag: a timer event wins over the clearing read
    always_ff @(posedge clk) begin
        if (rst)
            ready_q <= 1'b0;
        else if (acc_stb)
            ready_q <= 1'b1;
        else if (rd_en && addr == A_STATUS)
            ready_q <= 1'b0;
    end
    assign irq_o = ready_q;

    always_comb begin
        rdata = '0;
        case (addr)
            A_CODE_FRAC:   rdata = code_snap_frac;
            A_CODE_HC:     rdata = {{(BUS_W - HC_W){1'b0}}, code_snap_hc};
            A_CARR_FRAC:   rdata = meas_q[0].frac;
            A_CARR_CYC_LO: rdata = lower_half(meas_q[0].cycles);
            A_CARR_CYC_HI: rdata = upper_half(meas_q[0].cycles);
            A_SUB_FRAC:    rdata = meas_q[1].frac;
            A_SUB_CYC_LO:  rdata = lower_half(meas_q[1].cycles);
            A_SUB_CYC_HI:  rdata = upper_half(meas_q[1].cycles);
            A_STATUS:      rdata = {{(BUS_W - 1){1'b0}}, ready_q};
            default:       rdata = '0;
        endcase
    end
endmodule

// File: rtl/trk_meas_chk.sv
module trk_meas_chk
    import trk_pkg::*;
#(
    parameter int HALF_CHIPS = 2046,
    localparam int HC_W      = $clog2(HALF_CHIPS)
) (
    input logic              clk,
    input logic              rst,
    input logic              samp_en,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              tic_o,
    input logic              irq_o,
    input logic              acc_stb,
    input logic [PH_W-1:0]   carr_inc,
    input logic [PH_W-1:0]   carr_cycles,
    input logic [HC_W-1:0]   code_snap_hc
);
    // R2
    inc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_CARR_INC_LO) |=> $stable(carr_inc));

    // R5
    hc_range_chk: assert property (@(posedge clk) disable iff (rst)
        code_snap_hc < HC_W'(HALF_CHIPS));

    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tic_o |=> $stable(carr_cycles) && $stable(code_snap_hc));

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        acc_stb |=> irq_o);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_STATUS && !acc_stb) |=> !irq_o);

    // R10
    idle_event_chk: assert property (@(posedge clk) disable iff (rst)
        !samp_en |-> !tic_o && !acc_stb);
endmodule

bind trk_meas_unit trk_meas_chk #(.HALF_CHIPS(HALF_CHIPS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .samp_en      (samp_en),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .tic_o        (tic_o),
    .irq_o        (irq_o),
    .acc_stb      (acc_stb),
    .carr_inc     (wide_val[0]),
    .carr_cycles  (meas_q[0].cycles),
    .code_snap_hc (code_snap_hc)
);

// File: tb/sim_trk_meas_unit.sv
module sim_trk_meas_unit;
    localparam int CLK_PERIOD = 10;
    localparam int HC = 2046;
    localparam longint MASK = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        samp_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        tic_o;
    logic        irq_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trk_meas_unit #(.HALF_CHIPS(HC), .ACC_W(16)) u0 (
        .clk(clk), .rst(rst), .samp_en(samp_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .tic_o(tic_o), .irq_o(irq_o)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int tic_seen = 0;

    // behavioural reference state
    longint m_inc[4];
    longint m_stage[4];
    longint m_acc[3];
    longint m_cyc[2];
    longint m_snapcyc[2];
    longint m_snapph[3];
    longint m_ticcnt, m_accper, m_acccnt;
    int     m_hc, m_snaphc, m_slew;
    bit     m_flag;

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(int a);
        case (a)
            16, 18, 21:     return "R1/R4";
            17:             return "R5";
            19, 20, 22, 23: return "R6";
            24:             return "R9";
            default:        return "R4";
        endcase
    endfunction

    function automatic longint exp_rdata(int a);
        case (a)
            16: return (m_snapph[1] >> 16) & 16'hFFFF;
            17: return m_snaphc;
            18: return (m_snapph[0] >> 16) & 16'hFFFF;
            19: return m_snapcyc[0] & 16'hFFFF;
            20: return (m_snapcyc[0] >> 16) & 16'hFFFF;
            21: return (m_snapph[2] >> 16) & 16'hFFFF;
            22: return m_snapcyc[1] & 16'hFFFF;
            23: return (m_snapcyc[1] >> 16) & 16'hFFFF;
            24: return longint'(m_flag);
            default: return 0;
        endcase
    endfunction

    task automatic model_step(bit se, bit we, bit re, int a, int d, bit tnow, bit anow);
        longint cr[3];
        for (int k = 0; k < 3; k++) cr[k] = 0;
        if (se) begin
            for (int k = 0; k < 3; k++) begin
                longint s = m_acc[k] + m_inc[k];
                cr[k] = s >> 32;
                m_acc[k] = s & MASK;
            end
            if (cr[1] != 0) begin
                if (m_slew > 0) m_slew--;
                else m_hc = (m_hc + 1) % HC;
            end
            for (int j = 0; j < 2; j++) begin
                longint c = m_cyc[j] + cr[j == 0 ? 0 : 2];
                if (tnow) begin
                    m_snapcyc[j] = c;
                    m_cyc[j] = 0;
                end else m_cyc[j] = c;
            end
            if (tnow) begin
                for (int k = 0; k < 3; k++) m_snapph[k] = m_acc[k];
                m_snaphc = m_hc;
            end
            m_ticcnt = (tnow || m_inc[3] == 0) ? 0 : m_ticcnt + 1;
            m_acccnt = (anow || m_accper == 0) ? 0 : m_acccnt + 1;
        end
        if (anow) m_flag = 1;
        else if (re && a == 24) m_flag = 0;
        if (we) begin
            if (a < 8) begin
                if (a % 2 == 0) m_stage[a / 2] = d;
                else m_inc[a / 2] = (m_stage[a / 2] << 16) | longint'(d);
                if (a == 7) m_ticcnt = 0;
            end else if (a == 8) begin
                m_accper = d;
                m_acccnt = 0;
            end else if (a == 9) m_slew = d;
        end
    endtask

    task automatic cyc(bit se, bit we, bit re, int a, int d, string rq = "");
        bit tnow, anow;
        @(negedge clk);
        samp_en = se; wr_en = we; rd_en = re; addr = 5'(a); wdata = 16'(d);
        #1;
        tnow = se && m_inc[3] != 0 && m_ticcnt == m_inc[3] - 1;
        anow = se && m_accper != 0 && m_acccnt == m_accper - 1;
        if (tic_o) tic_seen++;
        chk("R3", longint'(tic_o), longint'(tnow));
        chk("R8", longint'(irq_o), longint'(m_flag));
        chk(rq == "" ? req_of(a) : rq, longint'(rdata), exp_rdata(a));
        @(posedge clk);
        model_step(se, we, re, a, d, tnow, anow);
    endtask

    task automatic wr(int a, int d);
        cyc(1, 1, 0, a, d);
    endtask

    task automatic run(int n, int se_mode);
        for (int i = 0; i < n; i++) begin
            bit se = (se_mode == 0) ? 1'b1 : (se_mode == 1) ? ((i % 4) != 3) : 1'b0;
            int a = 16 + (i % 9);
            cyc(se, 0, (i % 5) == 0, a, 0);
        end
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin m_inc[k] = 0; m_stage[k] = 0; end
        for (int k = 0; k < 3; k++) begin m_acc[k] = 0; m_snapph[k] = 0; end
        for (int k = 0; k < 2; k++) begin m_cyc[k] = 0; m_snapcyc[k] = 0; end
        m_ticcnt = 0; m_accper = 0; m_acccnt = 0;
        m_hc = 0; m_snaphc = 0; m_slew = 0; m_flag = 0;

        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: reset state seen at the ports
        for (int a = 16; a <= 24; a++) begin
            @(negedge clk);
            addr = 5'(a);
            #1;
            chk("R12", longint'(rdata), 0);
        end
        chk("R12", longint'(tic_o), 0);
        chk("R12", longint'(irq_o), 0);

        // program increments and timers
        wr(0, 16'h4000); wr(1, 16'h0000);
        wr(2, 16'h9000); wr(3, 16'h0001);
        wr(4, 16'h1234); wr(5, 16'h5678);
        wr(8, 13);
        wr(6, 0); wr(7, 50);
        run(400, 1);

        // R2: upper half alone must not change the carrier step
        wr(0, 16'h8000);
        run(120, 0);
        cyc(0, 0, 0, 19, 0, "R2");
        wr(1, 16'h0000);
        run(120, 1);
        cyc(0, 0, 0, 19, 0, "R2");

        // R7: slew five half chips, then rewrite mid-way
        wr(9, 5);
        run(60, 0);
        cyc(0, 0, 0, 17, 0, "R7");
        wr(9, 3);
        run(150, 1);
        cyc(0, 0, 0, 17, 0, "R7");

        // R5: drive the code position through its wrap
        wr(2, 16'hF000); wr(3, 16'h0000);
        wr(6, 0); wr(7, 97);
        run(2600, 0);
        cyc(0, 0, 0, 17, 0, "R5");

        // R9: clearing read while no accumulation event
        wr(8, 7);
        run(10, 0);
        cyc(0, 0, 1, 24, 0, "R9");
        cyc(0, 0, 0, 24, 0, "R9");
        chk("R9", longint'(irq_o), 0);

        // R10: sample enable low, short TIC period
        wr(6, 0); wr(7, 3);
        tic_seen = 0;
        run(60, 2);
        chk("R10", tic_seen, 0);

        // R11: zero periods disable both timers
        wr(7, 0); wr(8, 0);
        cyc(1, 1, 1, 24, 0);
        tic_seen = 0;
        run(150, 0);
        chk("R11", tic_seen, 0);
        chk("R11", longint'(irq_o), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule